// File: doc/BRIEF.md
# Infrared Pulse-Width Symbol Classifier

This block sits behind a demodulated infrared receiver and turns each high pulse on its input into a symbol. The input passes through a two-flop synchronizer. An edge detector then starts a duration counter on each rising edge. The counter advances once per system clock while the line stays high. On the falling edge the count is captured into a holding register and the counter is cleared, ready for the next pulse.

The captured duration is compared against three open windows, one each for a logic zero, a logic one and a start symbol. Each window is a lower and an upper bound, and a match must lie strictly between them. A one is longer than a zero, and a start is longer than both. If the windows overlap, start wins over one and one wins over zero. The block reports a result one clock after the capture:
- a one-cycle valid strobe with a 2-bit symbol code when a window matches;
- a one-cycle error strobe when no window matches.

The last captured duration stays visible on a debug output.

Top module: `irpw_classifier`

## Requirements
- R1: The result strobe for a pulse appears in the fourth clock cycle after the input falls: the synchronizer, the edge detector, the capture register and the classifier register each add one cycle.
- R2: The measured duration equals the number of clock cycles the input was high. Every pulse is measured from zero, regardless of earlier pulses.
- R3: The counter saturates at 2^CNT_W-1 rather than wrapping. A pulse that reaches it reports that value, and it falls into no window with the default bounds.
- R4: A duration d with ZERO_LO < d < ZERO_HI gives a valid strobe with symbol code 2'b00.
- R5: A duration d with ONE_LO < d < ONE_HI gives a valid strobe with symbol code 2'b01. The bounds themselves are excluded.
- R6: A duration d with START_LO < d < START_HI gives a valid strobe with symbol code 2'b10. The bounds themselves are excluded.
- R7: A duration inside no window gives an error strobe with symbol code 2'b11, and no valid strobe.
- R8: Each pulse produces exactly one strobe, valid or error, lasting one clock. No strobe occurs at any other time, and the two strobes are never high together.
- R9: After reset both strobes are low and the duration output is zero. The duration output holds the last captured value until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated receiver line, active high |
| sym_valid | output | 1 | One-cycle strobe: a symbol was recognised |
| sym_err | output | 1 | One-cycle strobe: the pulse matched no window |
| sym_code | output | 2 | 00 zero, 01 one, 10 start, 11 no match |
| dur_q | output | CNT_W | Last captured pulse duration in clocks |

## Verification
The assertions assume that every high or low stretch on the synchronized line lasts at least one clock. This means capture strobes are at least two cycles apart and a strobe never follows another directly. The assertions also assume that the line is low when reset is released, so no fall event can precede a rise. The stimulus drives the input on falling clock edges and holds it for whole cycles. It keeps every low gap at five cycles or more, so each result appears before the next pulse ends. The stimulus also starts low after reset.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO  = 2'b00,
    SYM_ONE   = 2'b01,
    SYM_START = 2'b10,
    SYM_NONE  = 2'b11
  } irpw_sym_e;

  // Window indices, ordered by rising priority.
  localparam int unsigned WIN_ZERO  = 0;
  localparam int unsigned WIN_ONE   = 1;
  localparam int unsigned WIN_START = 2;
  localparam int unsigned WIN_COUNT = 3;

  // Open interval test: both bounds excluded.
  function automatic logic in_window(logic [31:0] d, logic [31:0] lo, logic [31:0] hi);
    return (d > lo) && (d < hi);
  endfunction

  // Saturating increment at the all-ones value of a W-bit counter.
  function automatic logic [31:0] sat_next(logic [31:0] cur, logic [31:0] maxv);
    return (cur >= maxv) ? maxv : cur + 32'd1;
  endfunction

  // Hit vector to symbol, start > one > zero.
  function automatic irpw_sym_e pick_symbol(logic [WIN_COUNT-1:0] hit);
    if (hit[WIN_START]) return SYM_START;
    if (hit[WIN_ONE])   return SYM_ONE;
    if (hit[WIN_ZERO])  return SYM_ZERO;
    return SYM_NONE;
  endfunction

endpackage

// File: rtl/irpw_sync.sv
module irpw_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic meta_q;
  logic sync_q;
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~last_q;
  assign fall  = ~sync_q & last_q;

endmodule

// File: rtl/irpw_timer.sv
module irpw_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level,
  input  logic         rise,
  input  logic         fall,
  output logic [W-1:0] cnt,
  output logic [W-1:0] dur,
  output logic         cap_stb
);

  import irpw_pkg::*;

  localparam logic [31:0] CNT_MAX = 32'((64'd1 << W) - 64'd1);

  logic [31:0] cnt_ext;
  logic [31:0] cnt_inc;

  assign cnt_ext = 32'(cnt);
  assign cnt_inc = sat_next(cnt_ext, CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (rise) begin
      cnt <= W'(1);
    end else if (fall) begin
      cnt <= '0;
    end else if (level) begin
      cnt <= cnt_inc[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur     <= '0;
      cap_stb <= 1'b0;
    end else begin
      cap_stb <= fall;
      if (fall) dur <= cnt;
    end
  end

endmodule

// File: rtl/irpw_window.sv
module irpw_window #(
  parameter int unsigned W  = 8,
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 1
) (
  input  logic [W-1:0] dur,
  output logic         hit
);

  import irpw_pkg::*;

  assign hit = in_window(32'(dur), 32'(LO), 32'(HI));

endmodule

// File: rtl/irpw_classifier.sv
module irpw_classifier #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned ZERO_LO  = 2,
  parameter int unsigned ZERO_HI  = 8,
  parameter int unsigned ONE_LO   = 9,
  parameter int unsigned ONE_HI   = 20,
  parameter int unsigned START_LO = 30,
  parameter int unsigned START_HI = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  output logic             sym_valid,
  output logic             sym_err,
  output logic [1:0]       sym_code,
  output logic [CNT_W-1:0] dur_q
);

  import irpw_pkg::*;

  // Named internal events, also seen by the bound checker.
  logic                 lvl;
  logic                 rise_ev;
  logic                 fall_ev;
  logic [CNT_W-1:0]     run_cnt;
  logic [CNT_W-1:0]     cap_dur;
  logic                 cap_ev;
  logic [WIN_COUNT-1:0] win_hit;
  irpw_sym_e            sym_next;

  irpw_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ir_in),
    .level (lvl),
    .rise  (rise_ev),
    .fall  (fall_ev)
  );

  irpw_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (lvl),
    .rise    (rise_ev),
    .fall    (fall_ev),
    .cnt     (run_cnt),
    .dur     (cap_dur),
    .cap_stb (cap_ev)
  );

  for (genvar g = 0; g < WIN_COUNT; g++) begin : g_win
    localparam int unsigned LO = (g == WIN_ZERO) ? ZERO_LO :
                                 (g == WIN_ONE)  ? ONE_LO  : START_LO;
    localparam int unsigned HI = (g == WIN_ZERO) ? ZERO_HI :
                                 (g == WIN_ONE)  ? ONE_HI  : START_HI;
    irpw_window #(.W(CNT_W), .LO(LO), .HI(HI)) u_win (
      .dur (cap_dur),
      .hit (win_hit[g])
    );
  end

  assign sym_next = pick_symbol(win_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      sym_err   <= 1'b0;
      sym_code  <= SYM_ZERO;
    end else begin
      sym_valid <= cap_ev & (sym_next != SYM_NONE);
      sym_err   <= cap_ev & (sym_next == SYM_NONE);
      if (cap_ev) sym_code <= sym_next;
    end
  end

  assign dur_q = cap_dur;

endmodule

// File: rtl/irpw_checker.sv
module irpw_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         level,
  input logic         rise,
  input logic         fall,
  input logic [W-1:0] cnt,
  input logic [W-1:0] dur,
  input logic         cap_stb,
  input logic         sym_valid,
  input logic         sym_err,
  input logic [1:0]   sym_code
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  // R2
  rise_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt == W'(1)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level && !rise && cnt != MAXV) |=> (cnt == $past(cnt) + W'(1)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level && !rise && cnt == MAXV) |=> (cnt == MAXV));

  // R9
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (dur == $past(cnt) && cnt == '0));

  // R9
  dur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(dur));

  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (sym_valid != sym_err));

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> (!sym_valid && !sym_err));

  // R7
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err |-> (sym_code == 2'b11));

  // R4
  valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (sym_code != 2'b11));

  // R8
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid || sym_err) |=> (!sym_valid && !sym_err));

endmodule

bind irpw_classifier irpw_checker #(.W(CNT_W)) u_irpw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .level     (lvl),
  .rise      (rise_ev),
  .fall      (fall_ev),
  .cnt       (run_cnt),
  .dur       (cap_dur),
  .cap_stb   (cap_ev),
  .sym_valid (sym_valid),
  .sym_err   (sym_err),
  .sym_code  (sym_code)
);

// File: tb/test_irpw_classifier.sv
`timescale 1ns/1ps
module test_irpw_classifier;

  localparam int W  = 8;
  localparam int ZL = 2,  ZH = 8;
  localparam int OL = 9,  OH = 20;
  localparam int SL = 30, SH = 60;
  localparam int SAT = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ir_in = 1'b0;
  logic         sym_valid;
  logic         sym_err;
  logic [1:0]   sym_code;
  logic [W-1:0] dur_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irpw_classifier #(
    .CNT_W(W), .ZERO_LO(ZL), .ZERO_HI(ZH), .ONE_LO(OL), .ONE_HI(OH),
    .START_LO(SL), .START_HI(SH)
  ) i_irpw_classifier (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in),
    .sym_valid(sym_valid), .sym_err(sym_err), .sym_code(sym_code), .dur_q(dur_q)
  );

  function automatic int exp_dur(int h);
    return (h > SAT) ? SAT : h;
  endfunction

  // Inclusive form of the open windows: lo+1 .. hi-1.
  function automatic int exp_code(int d);
    if (d >= SL + 1 && d <= SH - 1) return 2;
    if (d >= OL + 1 && d <= OH - 1) return 1;
    if (d >= ZL + 1 && d <= ZH - 1) return 0;
    return 3;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // High for h clocks, then low for l clocks (l >= 5).
  task automatic send_pulse(int h, int l);
    int d, c;
    d = exp_dur(h);
    c = exp_code(d);
    @(negedge clk) ir_in = 1'b1;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      if (i < h - 1) check(!sym_valid && !sym_err, "R8 quiet while high", int'(sym_valid | sym_err), 0);
    end
    ir_in = 1'b0;
    for (int k = 1; k <= l; k++) begin
      @(negedge clk);
      if (k == 4) begin
        if (c == 3) begin
          check(sym_err && !sym_valid, "R7 error strobe", int'({sym_err, sym_valid}), 2);
        end else begin
          check(sym_valid && !sym_err, "R1 valid strobe latency", int'({sym_err, sym_valid}), 1);
          case (c)
            0: check(sym_code == 2'b00, "R4 zero code", int'(sym_code), c);
            1: check(sym_code == 2'b01, "R5 one code", int'(sym_code), c);
            default: check(sym_code == 2'b10, "R6 start code", int'(sym_code), c);
          endcase
        end
        check(int'(sym_code) == c, "R7 symbol code", int'(sym_code), c);
        if (h > SAT) check(int'(dur_q) == d, "R3 saturated duration", int'(dur_q), d);
        else         check(int'(dur_q) == d, "R2 duration", int'(dur_q), d);
      end else begin
        check(!sym_valid && !sym_err, "R8 single strobe", int'({sym_err, sym_valid}), 0);
      end
    end
    check(int'(dur_q) == d, "R9 duration held", int'(dur_q), d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!sym_valid && !sym_err, "R9 reset strobes", int'({sym_err, sym_valid}), 0);
    check(dur_q == '0, "R9 reset duration", int'(dur_q), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!sym_valid && !sym_err, "R9 idle after reset", int'({sym_err, sym_valid}), 0);

    // Directed window boundaries.
    send_pulse(1, 5);          // R7 too short
    send_pulse(ZL, 5);         // R7 lower bound excluded
    send_pulse(ZL + 1, 6);     // R4
    send_pulse(ZH - 1, 5);     // R4
    send_pulse(ZH, 5);         // R7
    send_pulse(OL, 5);         // R7 gap
    send_pulse(OL + 1, 7);     // R5
    send_pulse(OH - 1, 5);     // R5
    send_pulse(OH, 5);         // R5 upper bound excluded
    send_pulse(SL, 5);         // R6 lower bound excluded
    send_pulse(SL + 1, 5);     // R6
    send_pulse(SH - 1, 5);     // R6
    send_pulse(SH, 5);         // R6 upper bound excluded
    send_pulse(SAT - 1, 5);    // R3 just below saturation
    send_pulse(SAT + 45, 6);   // R3 saturation
    send_pulse(ZL + 2, 5);     // R2 fresh count after saturated pulse

    // Constrained random pulses.
    for (int n = 0; n < 60; n++) begin
      int h, l;
      h = int'($urandom_range(1, 70));
      l = int'($urandom_range(5, 9));
      send_pulse(h, l);
    end

    done = 1'b1;
    report();
  end

endmodule